// File: doc/BRIEF.md
# Printer Port Register File

This block is a byte-wide register file that looks like a classic PC printer port running in compatibility mode. A host reaches three registers over a simple synchronous bus: outgoing data, printer status and port control. A control write with the right combination of bits hands the data byte to a byte-out port, marked by a one-cycle valid pulse. The status register stands in for a printer: it walks its busy and acknowledge bits through a short sequence, one step for each status read. A level interrupt request is raised on a control-write pattern. A separate input lets the surrounding logic load an incoming byte, which the host reads back when the direction bit is set.

Read data is registered and appears one cycle after the read strobe. Any side effects of a status read take effect on the same clock edge as that strobe. When a read and a write arrive in the same cycle, the read is served and the write is dropped.

Top module: `printer_port_regs`

## Requirements
- R1: After reset, offset 0 reads 0xFF, offset 1 (status) reads 0xD9, offset 2 (control) reads 0xCC, and `irq` is low.
- R2: Only address bits [2:0] are decoded. Any access whose low bits are 3 to 7 reads 0xFF, and a write to such an offset leaves all registers unchanged.
- R3: Bits 7 and 6 of every value written to control are forced to 1 before it is stored. Reading control returns the stored value.
- R4: A control write with bit 2 (init) equal to 0 loads status with 0xD8.
- R5: A control write with bit 2 (init), bit 3 (select) and bit 0 (strobe) all set clears status bit 7. If the strobe bit stored before the write was 0, the data byte also appears on `out_byte`, with `out_valid` high for exactly one cycle.
- R6: A control write with init and select set and strobe clear sets the interrupt-pending flag, but only when bit 4 of the control value stored before the write was 1. `irq` equals the pending flag.
- R7: A read of offset 0 returns the incoming byte when control bit 5 is 1, and the last written data byte otherwise.
- R8: A read of offset 1 returns the status value from before the read and clears the pending flag.
- R9: After a status read, if status bit 7 and stored strobe bit are both 0: when bit 6 (ack) is 1 it is cleared; otherwise bits 7 and 6 are both set.
- R10: A cycle with `in_load` high stores `in_byte` as the incoming byte.
- R11: When `rd_en` and `wr_en` are high in the same cycle, the write is ignored.
- R12: `rd_data` carries the result of a read on the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address, low 3 bits decoded |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| in_load | input | 1 | Load the incoming byte |
| in_byte | input | 8 | Incoming byte value |
| out_byte | output | 8 | Emitted data byte |
| out_valid | output | 1 | One-cycle pulse when out_byte is emitted |
| irq | output | 1 | Level interrupt request |

## Verification
The bench repeats the strobe-high control write. A design that fires on the level of the strobe bit, and not on its rising edge, would emit the byte a second time. It runs status reads with strobe low and with strobe high. A wrong ack/busy walk shows up as a read value that differs from the bench model within two reads. It sets interrupt enable in the same write that clears strobe, and also beforehand. A design that tests the new enable bit instead of the stored one would raise `irq` too early. It also aliases addresses through the upper bits and issues reads and writes in the same cycle. Full-width decoding or a write that slips through would then corrupt later readbacks.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int BYTE_W  = 8;
  localparam int DEC_W   = 3;
  localparam logic [DEC_W-1:0] OFF_DATA = 3'd0;
  localparam logic [DEC_W-1:0] OFF_STAT = 3'd1;
  localparam logic [DEC_W-1:0] OFF_CTRL = 3'd2;
  // control bit positions
  localparam int C_STB = 0;
  localparam int C_INI = 2;
  localparam int C_SEL = 3;
  localparam int C_IEN = 4;
  localparam int C_DIR = 5;
  // status bit positions
  localparam int S_ACK = 6;
  localparam int S_BSY = 7;
  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
  localparam logic [BYTE_W-1:0] STAT_RST   = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_INIT  = 8'hD8;
  localparam logic [BYTE_W-1:0] BYTE_ONES  = 8'hFF;
endpackage

// File: rtl/pp_data_path.sv
module pp_data_path
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_wr,
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              in_load,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [BYTE_W-1:0] ctl_val,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] dataw_q,
  output logic [BYTE_W-1:0] datar_q,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid
);
  logic emit;

  assign ctl_val = wdata | CTRL_FORCE;
  assign emit = ctl_wr && ctl_val[C_INI] && ctl_val[C_SEL] &&
                ctl_val[C_STB] && !ctrl_q[C_STB];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_RST;
      dataw_q   <= BYTE_ONES;
      datar_q   <= BYTE_ONES;
      out_byte  <= BYTE_ONES;
      out_valid <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) out_byte <= dataw_q;
      if (ctl_wr) ctrl_q <= ctl_val;
      if (dat_wr) dataw_q <= wdata;
      if (in_load) datar_q <= in_byte;
    end
  end

  // R5: a byte leaves only on a stored-strobe rising edge
  p_emit_edge_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ctrl_q[C_STB] && !$past(ctrl_q[C_STB])));

  // R5: valid is a single-cycle pulse
  p_pulse_one_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R3: top control bits always read as one after any write
  p_ctrl_force_r3: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (ctrl_q[7:6] == 2'b11));
endmodule

// File: rtl/pp_status_unit.sv
module pp_status_unit
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] ctl_val,
  input  logic [BYTE_W-1:0] ctrl_q,
  input  logic              sts_rd,
  output logic [BYTE_W-1:0] status_q,
  output logic              pend_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= STAT_RST;
      pend_q   <= 1'b0;
    end else if (ctl_wr) begin
      if (!ctl_val[C_INI]) begin
        status_q <= STAT_INIT;
      end else if (ctl_val[C_SEL]) begin
        if (ctl_val[C_STB]) status_q[S_BSY] <= 1'b0;
        else if (ctrl_q[C_IEN]) pend_q <= 1'b1;
      end
    end else if (sts_rd) begin
      pend_q <= 1'b0;
      if (!status_q[S_BSY] && !ctrl_q[C_STB]) begin
        if (status_q[S_ACK]) begin
          status_q[S_ACK] <= 1'b0;
        end else begin
          status_q[S_ACK] <= 1'b1;
          status_q[S_BSY] <= 1'b1;
        end
      end
    end
  end

  // R8: status read drops the pending flag
  p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
    sts_rd |=> !pend_q);

  // R4: init low reloads status
  p_init_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_val[C_INI]) |=> (status_q == STAT_INIT));

  // R6: pending rises only with stored interrupt enable
  p_pend_enable_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(ctrl_q[C_IEN]));

  // R9: busy set again only through a status read or an init reload
  p_busy_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[S_BSY]) |-> $past(sts_rd || ctl_wr));
endmodule

// File: rtl/printer_port_regs.sv
module printer_port_regs
  import pp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              in_load,
  input  logic [7:0]        in_byte,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  output logic              irq
);
  logic [DEC_W-1:0]  off;
  logic              wr_act, dat_wr, ctl_wr, sts_rd;
  logic [BYTE_W-1:0] ctl_val, ctrl_q, dataw_q, datar_q, status_q;
  logic              pend_q;

  assign off    = bus_addr[DEC_W-1:0];
  assign wr_act = wr_en && !rd_en;
  assign dat_wr = wr_act && (off == OFF_DATA);
  assign ctl_wr = wr_act && (off == OFF_CTRL);
  assign sts_rd = rd_en && (off == OFF_STAT);

  generate
    if (ADDR_W > DEC_W) begin : g_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^bus_addr[ADDR_W-1:DEC_W];
    end
  endgenerate

  pp_data_path u_data (
    .clk(clk), .rst(rst), .dat_wr(dat_wr), .ctl_wr(ctl_wr),
    .wdata(wr_data), .in_load(in_load), .in_byte(in_byte),
    .ctl_val(ctl_val), .ctrl_q(ctrl_q), .dataw_q(dataw_q),
    .datar_q(datar_q), .out_byte(out_byte), .out_valid(out_valid)
  );

  pp_status_unit u_stat (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_val(ctl_val),
    .ctrl_q(ctrl_q), .sts_rd(sts_rd), .status_q(status_q), .pend_q(pend_q)
  );

  assign irq = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= BYTE_ONES;
    end else if (rd_en) begin
      case (off)
        OFF_DATA: rd_data <= ctrl_q[C_DIR] ? datar_q : dataw_q;
        OFF_STAT: rd_data <= status_q;
        OFF_CTRL: rd_data <= ctrl_q;
        default:  rd_data <= BYTE_ONES;
      endcase
    end
  end

  // R2: unused offsets read as all ones
  p_unused_read_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (off > OFF_CTRL)) |=> (rd_data == BYTE_ONES));

  // R11: a colliding write leaves control untouched
  p_collide_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en) |=> $stable(ctrl_q));

  // R12: status read data is the pre-read value
  p_stat_latency_r12: assert property (@(posedge clk) disable iff (rst)
    sts_rd |=> (rd_data == $past(status_q)));
endmodule

// File: tb/printer_port_regs_bench.sv
module printer_port_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] bus_addr;
  logic          wr_en, rd_en, in_load;
  logic [7:0]    wr_data, in_byte, rd_data, out_byte;
  logic          out_valid, irq;

  int n_checks = 0;
  int n_fail   = 0;

  // model state
  logic [7:0] m_dw, m_dr, m_st, m_ct;
  logic       m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  printer_port_regs #(.ADDR_W(AW)) u_printer_port_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .in_load(in_load), .in_byte(in_byte),
    .out_byte(out_byte), .out_valid(out_valid), .irq(irq)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] o);
    case (o)
      3'd0: return m_ct[5] ? m_dr : m_dw;
      3'd1: return m_st;
      3'd2: return m_ct;
      default: return 8'hFF;
    endcase
  endfunction

  // one bus cycle; inputs set at negedge, outputs checked at next negedge
  task automatic bus_op(input logic rd, input logic wr,
                        input logic [AW-1:0] a, input logic [7:0] d,
                        input string tag);
    logic [7:0] er, v;
    logic       emit;
    logic [2:0] o;
    o = a[2:0];
    er = 8'h00;
    emit = 1'b0;
    bus_addr = a; rd_en = rd; wr_en = wr; wr_data = d;
    if (rd) begin
      er = exp_read(o);
      if (o == 3'd1) begin
        m_pend = 1'b0;
        if (!m_st[7] && !m_ct[0]) begin
          if (m_st[6]) m_st[6] = 1'b0;
          else m_st[7:6] = 2'b11;
        end
      end
    end else if (wr) begin
      if (o == 3'd0) m_dw = d;
      else if (o == 3'd2) begin
        v = d | 8'hC0;
        if (!v[2]) m_st = 8'hD8;
        else if (v[3]) begin
          if (v[0]) begin
            m_st[7] = 1'b0;
            emit = !m_ct[0];
          end else if (m_ct[4]) m_pend = 1'b1;
        end
        m_ct = v;
      end
    end
    @(negedge clk);
    if (rd) check(rd_data == er, {tag, " R12 read"}, rd_data, er);
    check(out_valid == emit, {tag, " R5 valid"}, {7'd0, out_valid}, {7'd0, emit});
    if (emit) check(out_byte == m_dw, {tag, " R5 byte"}, out_byte, m_dw);
    check(irq == m_pend, {tag, " R6 irq"}, {7'd0, irq}, {7'd0, m_pend});
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic load_in(input logic [7:0] b);
    in_load = 1'b1; in_byte = b;
    @(negedge clk);
    in_load = 1'b0;
    m_dr = b;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input string t);
    bus_op(1'b0, 1'b1, a, d, t);
  endtask
  task automatic rdc(input logic [AW-1:0] a, input string t);
    bus_op(1'b1, 1'b0, a, 8'h00, t);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst = 1'b1; bus_addr = '0; wr_en = 0; rd_en = 0; wr_data = 0;
    in_load = 0; in_byte = 0;
    m_dw = 8'hFF; m_dr = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(irq == 1'b0, "R1 irq", {7'd0, irq}, 8'h00);
    rdc(8'h00, "R1 data");
    rdc(8'h02, "R1 ctrl");
    rdc(8'h01, "R1 status");
    // R2 unused offsets and aliasing
    wr(8'h05, 8'h00, "R2 unused wr");
    rdc(8'h02, "R2 ctrl kept");
    rdc(8'h07, "R2 unused rd");
    wr(8'hA2, 8'h1C, "R2 alias ctrl");
    rdc(8'h0A, "R2 alias rd");
    // R3/R4
    wr(8'h02, 8'h00, "R4 init low");
    rdc(8'h02, "R3 forced");
    rdc(8'h01, "R4 status");
    // R5 emission on edge only
    wr(8'h00, 8'h5A, "R5 data");
    wr(8'h02, 8'h1C, "R6 arm");
    wr(8'h02, 8'h1D, "R5 emit");
    wr(8'h02, 8'h1D, "R5 repeat no emit");
    wr(8'h02, 8'h1C, "R6 pend");
    // R8/R9 ack walk
    rdc(8'h01, "R8 stat1");
    rdc(8'h01, "R9 stat2");
    rdc(8'h01, "R9 stat3");
    // R6 enable in same write must not count
    wr(8'h02, 8'h0C, "R6 ien off");
    wr(8'h02, 8'h1C, "R6 same-write ien");
    // R7/R10 reverse read
    load_in(8'h3C);
    wr(8'h02, 8'h2C, "R7 dir");
    rdc(8'h00, "R7 in byte");
    wr(8'h02, 8'h0C, "R7 dir off");
    rdc(8'h00, "R7 out byte");
    // R11 collision
    bus_op(1'b1, 1'b1, 8'h02, 8'h00, "R11 collide");
    rdc(8'h02, "R11 ctrl kept");
    // random phase
    for (int i = 0; i < 400; i++) begin
      int unsigned k;
      logic [AW-1:0] a;
      logic [7:0] d;
      k = $urandom_range(0, 9);
      a = AW'($urandom);
      d = 8'($urandom);
      if (k < 3) a[2:0] = 3'd2;
      else if (k < 6) a[2:0] = 3'd1;
      if (k == 9) load_in(d);
      else if (k == 8) bus_op(1'b1, 1'b1, a, d, "R11 rand");
      else if (k[0]) wr(a, d, "R2 rand wr");
      else rdc(a, "R9 rand rd");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule